// File: doc/BRIEF.md
# Byte-Lane Banked Static Memory Module

This block is a 16-bit static memory that sits on a parallel bus with 24 address lines, 16 data lines and two active-low command strobes, one for reads and one for writes. It answers to a window of the address space that starts at a configurable base address. At full size the window is 1 MB: 512K words of 16 bits, stored in eight banks. Each bank is two byte-wide arrays, one for the low data byte and one for the high data byte. Every access may move one whole word or one byte.

Three fields come from the offset of the address within the window. Bit 0 and an active-low byte-high-enable input choose the byte lanes. The bits above the in-bank word index choose the bank. The bits between them index the word inside the bank. The data bus is modelled as a data output plus an output enable, and the enable is raised only for a read that falls inside the window and enables at least one lane. A write is registered on the clock. It takes effect when the write strobe returns high, using the address, data and byte enable that were sampled in the last cycle the strobe was low.

`OFS_W` sets the number of in-bank word index bits. The default of 6 keeps the arrays small. With `OFS_W` = 16 the window is the full 1 MB. `BASE_ADDR` must be a multiple of the window size.

Top module: `smem_banked`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `data_oe_o` is 0 and `data_o` is 0.
- R2: An access hits only when BASE_ADDR <= `addr_i` < BASE_ADDR + 2^(OFS_W+4) (the window is 1024 bytes by default). A read outside the window leaves `data_oe_o` at 0 and `data_o` at 0.
- R3: The low lane (bits 7:0) is enabled when `addr_i[0]` is 0. The high lane (bits 15:8) is enabled when `bhe_ni` is 0. Both together form a 16-bit access.
- R4: A 16-bit read at window offset o returns the byte at offset o on bits 7:0 and the byte at offset o+1 on bits 15:8.
- R5: A read of a single lane drives the disabled lane as zero.
- R6: A write commits on the first clock edge at which `wr_ni` is sampled high after being sampled low. It uses the address, data and `bhe_ni` sampled at the last edge at which `wr_ni` was low. Only enabled lanes change: the low lane takes `data_i[7:0]` and the high lane takes `data_i[15:8]`. While the strobe stays low, the stored data is unchanged.
- R7: With `addr_i[0]`=1 and `bhe_ni`=1 no lane is enabled: a read does not drive the bus and a write changes nothing.
- R8: Offset bits OFS_W+1 and up select one of 2^BANK_W banks, and offset bits OFS_W..1 select the word. Each bank holds its own data.
- R9: Read data and `data_oe_o` appear one clock edge after `rd_ni` is sampled low. `data_oe_o` falls one edge after `rd_ni` is sampled high.
- R10: When a read and a write commit to the same word fall on the same edge, the read returns the data held before the write.
- R11: A write outside the window changes no stored byte, including the bytes whose offset bits it would alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Byte address |
| bhe_ni | input | 1 | High byte enable, active low |
| rd_ni | input | 1 | Memory read strobe, active low |
| wr_ni | input | 1 | Memory write strobe, active low |
| data_i | input | 16 | Write data |
| data_o | output | 16 | Read data, zero when not driven |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
A read and a write commit can land on the same clock edge. The bench provokes this in two ways. In one, the read strobe falls at the same edge the write strobe rises, at the same word, and the read must return the old word (R10). In the other, a read is issued while the write strobe is still held low, and it must also return the old word, since nothing commits until the strobe rises (R6). Both cases are judged against a byte-level model of the window held in the bench. A later plain read then confirms the new value. Random mixes of in-window and out-of-window accesses with random lane choices exercise these collisions further.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic hi;
    logic lo;
  } lane_t;
endpackage

// File: rtl/smem_addr_dec.sv
module smem_addr_dec #(
  parameter int unsigned             ADDR_W    = 24,
  parameter int unsigned             BANK_W    = 3,
  parameter int unsigned             OFS_W     = 6,
  parameter logic [ADDR_W-1:0]       BASE_ADDR = 'hC0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [OFS_W-1:0]  word_o,
  output logic              a0_o
);
  localparam int unsigned TOP_LSB = OFS_W + BANK_W + 1;

  logic [ADDR_W:0] diff;

  // borrow lands in diff[ADDR_W]; any bit at or above TOP_LSB means out of window
  assign diff   = {1'b0, addr_i} - {1'b0, BASE_ADDR};
  assign hit_o  = (diff[ADDR_W:TOP_LSB] == '0);
  assign bank_o = diff[OFS_W+1 +: BANK_W];
  assign word_o = diff[1 +: OFS_W];
  assign a0_o   = diff[0];
endmodule

// File: rtl/smem_lane_dec.sv
module smem_lane_dec
  import smem_pkg::*;
(
  input  logic  bhe_ni,
  input  logic  a0_i,
  output lane_t lane_o
);
  always_comb begin
    lane_o.lo = ~a0_i;
    lane_o.hi = ~bhe_ni;
  end
endmodule

// File: rtl/smem_byte_array.sv
module smem_byte_array #(
  parameter int unsigned AW = 6,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read returns the pre-write content on a same-edge collision
  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/smem_banked.sv
module smem_banked
  import smem_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       BANK_W    = 3,
  parameter int unsigned       OFS_W     = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hC0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              bhe_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [15:0]       data_i,
  output logic [15:0]       data_o,
  output logic              data_oe_o
);
  localparam int unsigned NUM_BANKS = 1 << BANK_W;

  // read-side decode from live bus
  logic              r_hit, r_a0;
  logic [BANK_W-1:0] r_bank;
  logic [OFS_W-1:0]  r_word;
  lane_t             r_lane;
  logic              rd_go;

  smem_addr_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR)) u_rdec (
    .addr_i (addr_i),
    .hit_o  (r_hit),
    .bank_o (r_bank),
    .word_o (r_word),
    .a0_o   (r_a0)
  );

  smem_lane_dec u_rlane (.bhe_ni(bhe_ni), .a0_i(r_a0), .lane_o(r_lane));

  assign rd_go = ~rd_ni & r_hit & (r_lane.lo | r_lane.hi);

  // write capture: hold last values seen while strobe low
  logic              wr_low_q;
  logic [ADDR_W-1:0] wa_q;
  logic [15:0]       wd_q;
  logic              wbhe_q;
  logic              commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_low_q <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
      wbhe_q   <= 1'b1;
    end else begin
      wr_low_q <= ~wr_ni;
      if (!wr_ni) begin
        wa_q   <= addr_i;
        wd_q   <= data_i;
        wbhe_q <= bhe_ni;
      end
    end
  end

  assign commit = wr_low_q & wr_ni;

  logic              w_hit, w_a0;
  logic [BANK_W-1:0] w_bank;
  logic [OFS_W-1:0]  w_word;
  lane_t             w_lane;

  smem_addr_dec #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR)) u_wdec (
    .addr_i (wa_q),
    .hit_o  (w_hit),
    .bank_o (w_bank),
    .word_o (w_word),
    .a0_o   (w_a0)
  );

  smem_lane_dec u_wlane (.bhe_ni(wbhe_q), .a0_i(w_a0), .lane_o(w_lane));

  // bank storage
  logic [BYTE_W-1:0] lo_rd [NUM_BANKS];
  logic [BYTE_W-1:0] hi_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = commit & w_hit & (w_bank == BANK_W'(b));

    smem_byte_array #(.AW(OFS_W), .DW(BYTE_W)) u_lo (
      .clk_i   (clk_i),
      .we_i    (bank_wr & w_lane.lo),
      .waddr_i (w_word),
      .wdata_i (wd_q[BYTE_W-1:0]),
      .raddr_i (r_word),
      .rdata_o (lo_rd[b])
    );

    smem_byte_array #(.AW(OFS_W), .DW(BYTE_W)) u_hi (
      .clk_i   (clk_i),
      .we_i    (bank_wr & w_lane.hi),
      .waddr_i (w_word),
      .wdata_i (wd_q[DATA_W-1:BYTE_W]),
      .raddr_i (r_word),
      .rdata_o (hi_rd[b])
    );
  end

  // read return path
  logic              rd_hit_q;
  logic [BANK_W-1:0] rd_bank_q;
  lane_t             rd_lane_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_hit_q  <= 1'b0;
      rd_bank_q <= '0;
      rd_lane_q <= '0;
    end else begin
      rd_hit_q  <= rd_go;
      rd_bank_q <= r_bank;
      rd_lane_q <= r_lane;
    end
  end

  always_comb begin
    data_o = '0;
    if (rd_hit_q) begin
      if (rd_lane_q.lo) data_o[BYTE_W-1:0]      = lo_rd[rd_bank_q];
      if (rd_lane_q.hi) data_o[DATA_W-1:BYTE_W] = hi_rd[rd_bank_q];
    end
  end

  assign data_oe_o = rd_hit_q;
endmodule

// File: rtl/smem_banked_chk.sv
module smem_banked_chk #(
  parameter int unsigned       ADDR_W    = 24,
  parameter int unsigned       BANK_W    = 3,
  parameter int unsigned       OFS_W     = 6,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'hC0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              bhe_ni,
  input logic              rd_ni,
  input logic [15:0]       data_o,
  input logic              data_oe_o
);
  localparam logic [ADDR_W+1:0] LO_B = (ADDR_W+2)'(BASE_ADDR);
  localparam logic [ADDR_W+1:0] HI_B = LO_B + ((ADDR_W+2)'(1) << (OFS_W + BANK_W + 1));

  logic in_win;
  assign in_win = ({2'b00, addr_i} >= LO_B) && ({2'b00, addr_i} < HI_B);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (!data_oe_o && data_o == 16'h0));

  assert_oe_follows_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!rd_ni));

  assert_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_ni && !in_win) |-> !data_oe_o);

  assert_hi_lane_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(bhe_ni)) |-> data_o[15:8] == 8'h0);

  assert_lo_lane_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && $past(addr_i[0])) |-> data_o[7:0] == 8'h0);

  assert_no_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_ni && bhe_ni && addr_i[0]) |-> !data_oe_o);
endmodule

bind smem_banked smem_banked_chk #(
  .ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .bhe_ni    (bhe_ni),
  .rd_ni     (rd_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/smem_banked_tb.sv
module smem_banked_tb;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned BANK_W = 3;
  localparam int unsigned OFS_W  = 6;
  localparam logic [ADDR_W-1:0] BASE = 24'hC0000;
  localparam int unsigned WIN = 1 << (OFS_W + BANK_W + 1);
  localparam int unsigned BANK_BYTES = 1 << (OFS_W + 1);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic              bhe_ni = 1'b1;
  logic              rd_ni = 1'b1;
  logic              wr_ni = 1'b1;
  logic [15:0]       data_i = '0;
  logic [15:0]       data_o;
  logic              data_oe_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [7:0]  mdl [WIN];

  always #4 clk_i = ~clk_i;

  smem_banked #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W), .BASE_ADDR(BASE)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .bhe_ni(bhe_ni), .rd_ni(rd_ni),
    .wr_ni(wr_ni), .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  function automatic bit in_win(logic [ADDR_W-1:0] a);
    return (a >= BASE) && ({1'b0, a} < {1'b0, BASE} + (ADDR_W+1)'(WIN));
  endfunction

  function automatic int unsigned ofs(logic [ADDR_W-1:0] a);
    return int'(a - BASE);
  endfunction

  function automatic logic [16:0] exp_read(logic [ADDR_W-1:0] a, logic bhe);
    logic [15:0] d;
    bit lo, hi;
    d  = '0;
    lo = !a[0];
    hi = !bhe;
    if (!in_win(a) || !(lo || hi)) return 17'h0;
    if (lo) d[7:0]  = mdl[ofs(a) & ~1];
    if (hi) d[15:8] = mdl[ofs(a) | 1];
    return {1'b1, d};
  endfunction

  task automatic model_write(logic [ADDR_W-1:0] a, logic [15:0] d, logic bhe);
    if (in_win(a)) begin
      if (!a[0]) mdl[ofs(a) & ~1] = d[7:0];
      if (!bhe)  mdl[ofs(a) | 1]  = d[15:8];
    end
  endtask

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [ADDR_W-1:0] a, logic [15:0] d, logic bhe);
    @(negedge clk_i);
    addr_i = a; data_i = d; bhe_ni = bhe; wr_ni = 1'b0;
    @(negedge clk_i);
    wr_ni = 1'b1;
    @(posedge clk_i);
    model_write(a, d, bhe);
  endtask

  task automatic do_read(string req, logic [ADDR_W-1:0] a, logic bhe);
    @(negedge clk_i);
    addr_i = a; bhe_ni = bhe; rd_ni = 1'b0;
    @(negedge clk_i);
    chk(req, {data_oe_o, data_o}, exp_read(a, bhe));
    rd_ni = 1'b1;
  endtask

  function automatic logic [ADDR_W-1:0] rand_addr();
    int unsigned u = $urandom;
    case (u % 8)
      0:       return BASE - ADDR_W'(1 + ($urandom % 64));
      1:       return BASE + ADDR_W'(WIN) + ADDR_W'($urandom % 64);
      default: return BASE + ADDR_W'($urandom % WIN);
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", {data_oe_o, data_o}, 17'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", {data_oe_o, data_o}, 17'h0);

    // fill the whole window
    for (int w = 0; w < WIN / 2; w++) do_write(BASE + ADDR_W'(2 * w), 16'($urandom), 1'b0);

    do_read("R4 first word", BASE, 1'b0);
    do_read("R4 last word", BASE + ADDR_W'(WIN - 2), 1'b0);
    do_read("R2 below window", BASE - 2, 1'b0);
    do_read("R2 above window", BASE + ADDR_W'(WIN), 1'b0);
    do_read("R3 R5 low only", BASE + 24'h10, 1'b1);
    do_read("R3 R5 high only", BASE + 24'h11, 1'b0);
    do_read("R7 no lane read", BASE + 24'h21, 1'b1);

    // R7: no-lane write leaves word alone
    do_write(BASE + 24'h21, 16'hDEAD, 1'b1);
    do_read("R7 no lane write", BASE + 24'h20, 1'b0);

    // R6: single-lane writes
    do_write(BASE + 24'h31, 16'hA500, 1'b0);
    do_read("R6 high lane write", BASE + 24'h30, 1'b0);
    do_write(BASE + 24'h40, 16'h005A, 1'b1);
    do_read("R6 low lane write", BASE + 24'h40, 1'b0);

    // R8: same word index in every bank
    for (int b = 0; b < (1 << BANK_W); b++)
      do_write(BASE + ADDR_W'(b * BANK_BYTES + 6), 16'(16'h1100 * (b + 1) + b), 1'b0);
    for (int b = 0; b < (1 << BANK_W); b++)
      do_read("R8 bank data", BASE + ADDR_W'(b * BANK_BYTES + 6), 1'b0);

    // R9: enable drops one edge after read strobe returns high
    do_read("R9 read", BASE + 24'h8, 1'b0);
    @(negedge clk_i);
    chk("R9 oe released", {data_oe_o, data_o}, 17'h0);

    // R6: read while write strobe still low sees old data
    @(negedge clk_i);
    addr_i = BASE + 24'h50; data_i = 16'h1234; bhe_ni = 1'b0; wr_ni = 1'b0; rd_ni = 1'b0;
    @(negedge clk_i);
    chk("R6 no commit while low", {data_oe_o, data_o}, exp_read(BASE + 24'h50, 1'b0));
    rd_ni = 1'b1; wr_ni = 1'b1;
    @(posedge clk_i);
    model_write(BASE + 24'h50, 16'h1234, 1'b0);
    do_read("R6 committed", BASE + 24'h50, 1'b0);

    // R10: read and commit on the same edge
    @(negedge clk_i);
    addr_i = BASE + 24'h60; data_i = 16'hBEEF; bhe_ni = 1'b0; wr_ni = 1'b0;
    @(negedge clk_i);
    wr_ni = 1'b1; rd_ni = 1'b0;
    @(negedge clk_i);
    chk("R10 old data on collision", {data_oe_o, data_o}, exp_read(BASE + 24'h60, 1'b0));
    rd_ni = 1'b1;
    model_write(BASE + 24'h60, 16'hBEEF, 1'b0);
    do_read("R10 new data after", BASE + 24'h60, 1'b0);

    // R11: out-of-window writes that alias offsets 0 and WIN-2
    do_write(BASE + ADDR_W'(WIN), 16'hC3C3, 1'b0);
    do_write(BASE - 2, 16'h3C3C, 1'b0);
    do_read("R11 alias low end", BASE, 1'b0);
    do_read("R11 alias high end", BASE + ADDR_W'(WIN - 2), 1'b0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a = rand_addr();
      logic bhe = 1'($urandom);
      if ($urandom % 2) do_write(a, 16'($urandom), bhe);
      else do_read("R2 R3 R4 R5 R6 random", a, bhe);
    end
    for (int i = 0; i < 64; i++) do_read("R8 R11 sweep", BASE + ADDR_W'(2 * ($urandom % (WIN / 2))), 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule